// File: doc/BRIEF.md
# Coarse-Fine Redundant SAR Combiner

This block is the digital back end of a two-stage subranging successive-approximation converter. A start pulse hands it the 4-bit result of the coarse stage. It then runs a six-step fine search. Each step sets one trial bit on the capacitor-DAC control word and raises a comparator request. The step ends when the comparator reports a decision through a valid handshake. No fixed clock count governs a step, so the search moves on as soon as each decision arrives.

The fine weights are 16, 8, 8, 4, 2 and 1 units. One coarse step equals 16 fine units. The second 8 is a redundant step: together the steps reach 0 to 39 units, which is wider than the 16-unit coarse segment. This overlap lets the fine search absorb a coarse decision that was off by up to 8 units either way. After the last decision the block merges the coarse code and the kept fine weights into one 8-bit word and raises a one-cycle strobe. A watchdog stops a search whose comparator has stalled.

Top module: `sar_cf_combiner`

## Requirements
- R1: After reset, `result_valid`, `cmp_req`, `dac_ctrl` and `result` are all zero.
- R2: A `start` sampled while idle does three things: it captures `coarse_code`, it clears earlier decisions, and it opens step 0. In the next cycle `cmp_req` is 1 and `dac_ctrl` is 6'b100000.
- R3: During step i, `dac_ctrl` holds the kept decisions of earlier steps plus the trial bit of step i. Step i drives bit 5-i. A sampled `cmp_valid` with `cmp_dec`=1 keeps the bit and `cmp_dec`=0 clears it. The next step opens on that same edge.
- R4: A search takes exactly six decisions. The steps use weights 16, 8, 8, 4, 2, 1, which sit on `dac_ctrl` bits 5 down to 0. After the search, `dac_ctrl` shows the six kept bits until the next start.
- R5: `result` equals 16*coarse + (sum of the weights of the kept bits) - 8.
- R6: When that sum is below 0, `result` is 0. When it is above 255, `result` is 255. It never wraps.
- R7: `result_valid` is high for exactly one cycle: the cycle after the edge that took the last decision. `cmp_req` is low in that cycle. `result` then holds until the next search ends.
- R8: Each step has a watchdog. If no `cmp_valid` is sampled within 8 edges of the step opening, the search ends on the 8th edge. The pending and remaining decisions count as 0, and `result_valid` follows. A `cmp_valid` sampled on the 8th edge is still taken.
- R9: A `start` sampled during a search is ignored. The search, its captured coarse code and `dac_ctrl` all go on unchanged.
- R10: A `cmp_valid` sampled while idle has no effect on `result`, `result_valid` or `dac_ctrl`.
- R11: Take any input x from 0 to 255 and any coarse code that is off from x/16 by up to 8 units, then let the comparator follow the true residue. The result is then exactly x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample start; accepted only while idle |
| coarse_code | input | 4 | Coarse stage result, captured at start |
| cmp_req | output | 1 | High while a fine decision is awaited |
| cmp_valid | input | 1 | Comparator decision valid |
| cmp_dec | input | 1 | Comparator decision; 1 keeps the trial bit |
| dac_ctrl | output | 6 | Fine DAC control, bit 5 = weight 16 ... bit 0 = weight 1 |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 8 | Merged, saturated output code |

## Verification
Two things can land on the same edge: a comparator decision and the watchdog's expiry. The sweep provokes this by delaying the response to one step by exactly the watchdog limit. The response is then sampled on the expiry edge, and the result must still equal the full-search value. A directed case holds the comparator silent for one edge more. Its result must contain only the decisions taken before the stall, with zeros for the pending and later steps.

// File: rtl/sar_cf_pkg.sv
package sar_cf_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FINE = 1'b1
   } cf_state_e;

endpackage

// File: rtl/sar_cf_watchdog.sv
module sar_cf_watchdog #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expire
);

   generate
      if (LIMIT > 0) begin : g_count
         localparam int CNT_W = $clog2(LIMIT + 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!run || clr)   cnt_q <= '0;
            else                    cnt_q <= cnt_q + CNT_W'(1);
         end

         assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));
      end else begin : g_off
         assign expire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sar_cf_fine_ctrl.sv
module sar_cf_fine_ctrl
   import sar_cf_pkg::*;
#(
   parameter int FINE_N = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmp_valid,
   input  logic              cmp_dec,
   input  logic              expire,
   output logic              busy,
   output logic [FINE_N-1:0] trial,
   output logic [FINE_N-1:0] keep,
   output logic              finish,
   output logic [FINE_N-1:0] final_bits
);

   localparam int IDX_W = (FINE_N > 1) ? $clog2(FINE_N) : 1;

   cf_state_e         st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [FINE_N-1:0] keep_q;
   logic [FINE_N-1:0] taken;
   logic              last;

   assign busy  = (st_q == ST_FINE);
   assign trial = busy ? (FINE_N'(1) << (FINE_N - 1 - int'(idx_q))) : '0;
   assign taken = keep_q | (cmp_dec ? trial : '0);
   assign last  = (idx_q == IDX_W'(FINE_N - 1));

   assign finish     = busy && (cmp_valid ? last : expire);
   assign final_bits = cmp_valid ? taken : keep_q;
   assign keep       = keep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         keep_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_FINE;
                  idx_q  <= '0;
                  keep_q <= '0;
               end
            end
            default: begin
               if (cmp_valid) begin
                  keep_q <= taken;
                  idx_q  <= idx_q + IDX_W'(1);
                  if (last) st_q <= ST_IDLE;
               end else if (expire) begin
                  st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/sar_cf_merge.sv
module sar_cf_merge #(
   parameter int                        COARSE_W     = 4,
   parameter int                        FINE_N       = 6,
   parameter int                        WGT_W        = 6,
   parameter logic [FINE_N*WGT_W-1:0]   FINE_WEIGHTS = '0,
   parameter int                        SEG_UNITS    = 16,
   parameter int                        OFFSET       = 8,
   parameter bit                        SATURATE     = 1'b1,
   parameter int                        OUT_W        = 8
) (
   input  logic [COARSE_W-1:0] coarse,
   input  logic [FINE_N-1:0]   bits,
   output logic [OUT_W-1:0]    code
);

   localparam int SUM_W = OUT_W + WGT_W + 2;
   localparam logic [SUM_W-1:0] TOP_CODE = SUM_W'((1 << OUT_W) - 1);

   logic [SUM_W-1:0] raw;

   always_comb begin
      raw = SUM_W'(coarse) * SUM_W'(SEG_UNITS);
      for (int k = 0; k < FINE_N; k++) begin
         if (bits[k]) raw = raw + SUM_W'(FINE_WEIGHTS[k*WGT_W +: WGT_W]);
      end
      raw = raw - SUM_W'(OFFSET);
   end

   generate
      if (SATURATE) begin : g_sat
         assign code = raw[SUM_W-1]      ? '0 :
                       (raw > TOP_CODE)  ? '1 : raw[OUT_W-1:0];
      end else begin : g_wrap
         assign code = raw[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/sar_cf_combiner.sv
module sar_cf_combiner
   import sar_cf_pkg::*;
#(
   parameter int                      COARSE_W     = 4,
   parameter int                      FINE_N       = 6,
   parameter int                      WGT_W        = 6,
   parameter logic [FINE_N*WGT_W-1:0] FINE_WEIGHTS = {6'd16, 6'd8, 6'd8, 6'd4, 6'd2, 6'd1},
   parameter int                      SEG_UNITS    = 16,
   parameter int                      OFFSET       = 8,
   parameter int                      TIMEOUT      = 8,
   parameter bit                      SATURATE     = 1'b1,
   localparam int                     OUT_W        = COARSE_W + $clog2(SEG_UNITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [COARSE_W-1:0] coarse_code,
   output logic                cmp_req,
   input  logic                cmp_valid,
   input  logic                cmp_dec,
   output logic [FINE_N-1:0]   dac_ctrl,
   output logic                result_valid,
   output logic [OUT_W-1:0]    result
);

   function automatic int wt(input int k);
      return int'(FINE_WEIGHTS[k*WGT_W +: WGT_W]);
   endfunction

   function automatic int lower_sum(input int k);
      int s = 0;
      for (int j = 0; j < k; j++) s += wt(j);
      return s;
   endfunction

   // Elaboration-time parameter checks
   generate
      for (genvar k = 0; k < FINE_N; k++) begin : g_cover
         if (wt(k) > lower_sum(k) + 1) begin : g_gap
            $error("fine weight at bit %0d leaves a gap the later steps cannot fill", k);
         end
      end
      if (lower_sum(FINE_N) + 1 < SEG_UNITS + 2 * OFFSET) begin : g_range
         $error("fine range too narrow for segment plus overlap");
      end
      if ((SEG_UNITS & (SEG_UNITS - 1)) != 0) begin : g_seg
         $error("SEG_UNITS must be a power of two");
      end
   endgenerate

   logic                busy, finish, expire;
   logic [FINE_N-1:0]   trial, keep, final_bits;
   logic [COARSE_W-1:0] coarse_q;
   logic [OUT_W-1:0]    merged;
   logic                rv_q;
   logic [OUT_W-1:0]    res_q;

   sar_cf_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .clr    (cmp_valid),
      .expire (expire)
   );

   sar_cf_fine_ctrl #(.FINE_N(FINE_N)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cmp_valid  (cmp_valid),
      .cmp_dec    (cmp_dec),
      .expire     (expire),
      .busy       (busy),
      .trial      (trial),
      .keep       (keep),
      .finish     (finish),
      .final_bits (final_bits)
   );

   sar_cf_merge #(
      .COARSE_W     (COARSE_W),
      .FINE_N       (FINE_N),
      .WGT_W        (WGT_W),
      .FINE_WEIGHTS (FINE_WEIGHTS),
      .SEG_UNITS    (SEG_UNITS),
      .OFFSET       (OFFSET),
      .SATURATE     (SATURATE),
      .OUT_W        (OUT_W)
   ) u_merge (
      .coarse (coarse_q),
      .bits   (final_bits),
      .code   (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         rv_q     <= 1'b0;
         res_q    <= '0;
      end else begin
         if (start && !busy) coarse_q <= coarse_code;
         rv_q <= finish;
         if (finish) res_q <= merged;
      end
   end

   assign cmp_req      = busy;
   assign dac_ctrl     = keep | trial;
   assign result_valid = rv_q;
   assign result       = res_q;

endmodule

// File: rtl/sar_cf_checker.sv
module sar_cf_checker #(
   parameter int FINE_N  = 6,
   parameter int TIMEOUT = 8,
   parameter int OUT_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              cmp_req,
   input logic              cmp_valid,
   input logic [FINE_N-1:0] dac_ctrl,
   input logic              result_valid,
   input logic [OUT_W-1:0]  result
);

   localparam int DC_W = $clog2(FINE_N + 1);
   localparam logic [FINE_N-1:0] FIRST_TRIAL = {1'b1, {(FINE_N-1){1'b0}}};

   logic [DC_W-1:0] dcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     dcnt_q <= '0;
      else if (start && !cmp_req)     dcnt_q <= '0;
      else if (cmp_req && cmp_valid)  dcnt_q <= dcnt_q + DC_W'(1);
   end

   // R2: an accepted start opens step 0 with the top trial bit
   p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !cmp_req |=> cmp_req && (dac_ctrl == FIRST_TRIAL));

   // R3: DAC word stays put while a decision is awaited
   p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req && !cmp_valid |=> $stable(dac_ctrl) || !cmp_req);

   // R4: never more than FINE_N decisions in one search
   p_step_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req |-> dcnt_q < DC_W'(FINE_N));

   // R4: a search ended by a decision has taken all FINE_N of them
   p_full_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid && $past(cmp_valid) |-> dcnt_q == DC_W'(FINE_N));

   // R7: strobe lasts one cycle and the request is down with it
   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   p_req_low_on_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !cmp_req);

   // R10: idle without start leaves outputs untouched
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_req && !start |=> $stable(dac_ctrl) && $stable(result) && !cmp_req);

   generate
      if (TIMEOUT > 0) begin : g_wait
         localparam int WC_W = $clog2(TIMEOUT + 1);
         logic [WC_W-1:0] wcnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     wcnt_q <= '0;
            else if (!cmp_req || cmp_valid) wcnt_q <= '0;
            else                            wcnt_q <= wcnt_q + WC_W'(1);
         end

         // R8: no step waits beyond the watchdog limit
         p_wait_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_req |-> wcnt_q < WC_W'(TIMEOUT));
      end
   endgenerate

endmodule

bind sar_cf_combiner sar_cf_checker #(
   .FINE_N  (FINE_N),
   .TIMEOUT (TIMEOUT),
   .OUT_W   (OUT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .cmp_req      (cmp_req),
   .cmp_valid    (cmp_valid),
   .dac_ctrl     (dac_ctrl),
   .result_valid (result_valid),
   .result       (result)
);

// File: tb/sar_cf_combiner_test.sv
`timescale 1ns/1ps
module sar_cf_combiner_test;

   localparam int TMO = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] coarse_code = '0;
   logic       cmp_req;
   logic       cmp_valid = 1'b0;
   logic       cmp_dec = 1'b0;
   logic [5:0] dac_ctrl;
   logic       result_valid;
   logic [7:0] result;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int W [6] = '{16, 8, 8, 4, 2, 1};

   always #2 clk = ~clk;

   sar_cf_combiner uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .coarse_code  (coarse_code),
      .cmp_req      (cmp_req),
      .cmp_valid    (cmp_valid),
      .cmp_dec      (cmp_dec),
      .dac_ctrl     (dac_ctrl),
      .result_valid (result_valid),
      .result       (result)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int clampi(input int v, input int lo, input int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   // One sample: c = coarse code, r = residue in fine units seen by the comparator model.
   task automatic run_sample(input int c, input int r, input int pat, input int slow_step,
                             input int to_step, input bit poke, input int want, input string req);
      int acc = 0;
      logic [5:0] kept = '0;
      int d;
      int expv;
      bit dec;
      @(negedge clk); start = 1'b1; coarse_code = 4'(c);
      @(negedge clk); start = 1'b0;
      chk(cmp_req === 1'b1 && dac_ctrl === 6'b100000, "R2", int'(dac_ctrl), 32);
      for (int i = 0; i < 6; i++) begin
         logic [5:0] bitm;
         bitm = 6'b100000 >> i;
         if (i == to_step) begin
            repeat (TMO - 1) @(negedge clk);
            chk(cmp_req === 1'b1, "R8", int'(cmp_req), 1);
            @(negedge clk);
            break;
         end
         d = (i == slow_step) ? TMO : 1 + ((i + pat) % 3);
         if (poke && i == 2) begin
            start = 1'b1; coarse_code = 4'(c ^ 15);
            @(negedge clk);
            start = 1'b0; coarse_code = 4'(c);
            chk(cmp_req === 1'b1 && dac_ctrl === (kept | bitm), "R9", int'(dac_ctrl), int'(kept | bitm));
            repeat ((d >= 2) ? d - 2 : 0) @(negedge clk);
         end else begin
            repeat (d - 1) @(negedge clk);
         end
         chk(dac_ctrl === (kept | bitm), "R3", int'(dac_ctrl), int'(kept | bitm));
         dec = (r >= acc + W[i]);
         cmp_valid = 1'b1; cmp_dec = dec;
         @(negedge clk);
         cmp_valid = 1'b0; cmp_dec = 1'b0;
         if (dec) begin kept |= bitm; acc += W[i]; end
      end
      expv = clampi(16 * c + acc - 8, 0, 255);
      chk(result_valid === 1'b1, "R7", int'(result_valid), 1);
      chk(result === 8'(expv), req, int'(result), expv);
      chk(cmp_req === 1'b0 && dac_ctrl === kept, "R4", int'(dac_ctrl), int'(kept));
      if (want >= 0) chk(result === 8'(want), "R11", int'(result), want);
      @(negedge clk);
      chk(result_valid === 1'b0, "R7", int'(result_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(result_valid === 1'b0 && cmp_req === 1'b0 && dac_ctrl === 6'd0 && result === 8'd0,
          "R1", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Saturation corners (R6) and plain merge (R5)
      run_sample(0, -5, 0, -1, -1, 1'b0, -1, "R6");
      run_sample(15, 60, 1, -1, -1, 1'b0, -1, "R6");
      run_sample(15, 31, 2, -1, -1, 1'b0, -1, "R6");
      run_sample(7, 20, 0, -1, -1, 1'b0, -1, "R5");

      // Watchdog expiry mid-search and at step 0 (R8)
      run_sample(5, 27, 1, -1, 3, 1'b0, -1, "R8");
      run_sample(3, 20, 0, -1, 0, 1'b0, -1, "R8");
      // Decision arriving on the expiry edge is still taken (R8)
      run_sample(6, 33, 0, 4, -1, 1'b0, 6 * 16 + 25, "R8");

      // Start during a search is ignored (R9)
      run_sample(9, 13, 2, -1, -1, 1'b1, 149, "R9");

      // Idle comparator valid has no effect (R10)
      begin
         logic [7:0] r0;
         logic [5:0] d0;
         r0 = result; d0 = dac_ctrl;
         cmp_valid = 1'b1; cmp_dec = 1'b1;
         @(negedge clk);
         cmp_valid = 1'b0; cmp_dec = 1'b0;
         chk(result === r0 && dac_ctrl === d0 && result_valid === 1'b0, "R10", int'(result), int'(r0));
         @(negedge clk);
         chk(result_valid === 1'b0 && cmp_req === 1'b0, "R10", int'(result_valid), 0);
      end

      // Sweep of every input with coarse errors of -8, 0, +8 units (R11, R5)
      for (int x = 0; x < 256; x++) begin
         for (int ei = 0; ei < 3; ei++) begin
            int e;
            int c;
            int r;
            e = -8 + 8 * ei;
            c = (x + e < 0) ? 0 : clampi((x + e) / 16, 0, 15);
            r = x - 16 * c + 8;
            run_sample(c, r, x + ei, (x % 37 == 0) ? 2 * ei : -1, -1, 1'b0, x, "R5");
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R7: run did not complete, got 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule